// File: doc/BRIEF.md
# Ethernet Receive Framer with Station Address Filter

This block sits behind a Manchester decoder and receives one NRZ bit per clock while the carrier sense input is high. It looks for the start-of-frame delimiter and, once the delimiter is seen, assembles the following bits into bytes. It also runs a CRC over the frame. The first six bytes of the frame are the destination address. They are matched against a small table of station addresses. Each table entry can be switched on or off.

When an enabled entry matches all six address bytes, every byte after the address is written to a byte-wide receive FIFO write port. That includes the frame check sequence. When no entry matches, nothing is written. The frame ends when carrier sense drops. One clock later, a single-cycle done pulse carries the match result and three error flags: misaligned length, bad CRC and short (runt) frame. The address table is loaded through a one-cycle write port.

Top module: `rx_addr_framer`

## Requirements
- R1: While hunting, received bits only count toward a frame once the eight most recent bits seen with carrier high were 1,0,1,0,1,0,1,1 in arrival order. The bit after that pattern is bit 0 of frame byte 0.
- R2: Each frame byte is built from eight consecutive bits, least significant bit first.
- R3: Frame bytes 0 to 5 form the destination address. Byte 0 is compared with table bits [47:40], and so on down to byte 5, which is compared with bits [7:0]. The frame is a hit when all six bytes equal one enabled entry.
- R4: An entry whose enable bit is 0 never produces a hit, whatever its stored address.
- R5: On a hit, each byte from index 6 to the last complete byte (FCS included) is presented on `fifoWrData` with a one-cycle `fifoWrEn`, in arrival order. On a miss, `fifoWrEn` stays low for the whole frame.
- R6: When carrier sense is low in a clock cycle during reception, `frameDone` is high for exactly the following cycle. A carrier drop before the delimiter produces no `frameDone`.
- R7: With `frameDone`, `errAlign` is 1 exactly when the number of bits after the delimiter is not a multiple of 8.
- R8: With `frameDone`, `errCrc` is 1 exactly when the CRC-32 register does not hold 0xC704DD7B. The register uses polynomial 0x04C11DB7, starts at all ones, shifts left, and is fed with every bit after the delimiter in arrival order.
- R9: With `frameDone`, `errRunt` is 1 exactly when fewer than MIN_BYTES complete bytes followed the delimiter.
- R10: A table write stores the 48-bit address and its enable bit at the given index in one cycle. The write applies to every address byte compared after that cycle.
- R11: After reset, all outputs are 0 and every table entry is disabled. The flags `addrHit`, `errAlign`, `errCrc` and `errRunt` are 0 whenever `frameDone` is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | NRZ receive data, one bit per clock |
| carrierSense | input | 1 | High while a frame is on the wire |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | IDX_W | Table entry index for the write |
| tblWrMac | input | 48 | Station address to store |
| tblWrEnable | input | 1 | Enable bit to store with the address |
| fifoWrEn | output | 1 | FIFO write strobe for a forwarded byte |
| fifoWrData | output | 8 | Forwarded byte |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| addrHit | output | 1 | Destination matched an enabled entry |
| errAlign | output | 1 | Bit count after the delimiter not a multiple of 8 |
| errCrc | output | 1 | CRC residue wrong |
| errRunt | output | 1 | Fewer than MIN_BYTES bytes |

## Verification
The bench builds the block with four table entries and MIN_BYTES set to 16. With these values it can cover every entry and every position of a wrong address byte. It also sweeps frame lengths across the runt boundary and every count of trailing odd bits, all in short runs. Expected bytes, flags and CRC residues are computed in the bench from the bit stream it sends. It also rewrites the enable bits between frames and checks the hit result that follows.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [7:0]  SFD_PATTERN  = 8'b10101011;
  localparam logic [31:0] CRC_POLY     = 32'h04C11DB7;
  localparam logic [31:0] CRC_RESIDUE  = 32'hC704DD7B;
  localparam int          ADDR_BYTES   = 6;

  typedef struct packed {
    logic huntShift;
    logic huntClear;
    logic startFrame;
    logic shiftBit;
    logic endFrame;
  } rxfStrobes_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } rxfState_t;
endpackage

// File: rtl/rxf_addr_table.sv
module rxf_addr_table #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [47:0]        wrMac,
  input  logic               wrEnable,
  input  logic [2:0]         byteSel,
  input  logic [7:0]         byteVal,
  output logic [ENTRIES-1:0] eqVec
);
  logic [47:0]        macTbl [ENTRIES];
  logic [ENTRIES-1:0] enMask;
  logic [2:0]         revSel;
  logic [5:0]         bitBase;

  assign revSel  = (byteSel > 3'd5) ? 3'd0 : (3'd5 - byteSel);
  assign bitBase = {revSel, 3'b000};

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        macTbl[g] <= '0;
        enMask[g] <= 1'b0;
      end else if (wrEn && (wrIdx == IDX_W'(g))) begin
        macTbl[g] <= wrMac;
        enMask[g] <= wrEnable;
      end
    end
    assign eqVec[g] = enMask[g] && (macTbl[g][bitBase +: 8] == byteVal);
  end

  // R4: a disabled entry reports no equality
  a_r4_disabled_no_eq: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrEnable) |=> !eqVec[$past(wrIdx)]);
endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        carrierSense,
  input  logic        sfdNow,
  output rxfStrobes_t strb
);
  rxfState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_HUNT: begin
        if (carrierSense) begin
          strb.huntShift = 1'b1;
          if (sfdNow) begin
            strb.startFrame = 1'b1;
            stateNext       = ST_RECV;
          end
        end else begin
          strb.huntClear = 1'b1;
        end
      end
      ST_RECV: begin
        if (carrierSense) begin
          strb.shiftBit = 1'b1;
        end else begin
          strb.endFrame  = 1'b1;
          strb.huntClear = 1'b1;
          stateNext      = ST_HUNT;
        end
      end
      default: stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNext;
  end

  // R1: reception starts only after the delimiter was seen under carrier
  a_r1_recv_after_sfd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_RECV) |-> $past(sfdNow && carrierSense));
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int MIN_BYTES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxBit,
  input  rxfStrobes_t        strb,
  input  logic [ENTRIES-1:0] eqVec,
  output logic               sfdNow,
  output logic [2:0]         byteSel,
  output logic [7:0]         byteVal,
  output logic               fifoWrEn,
  output logic [7:0]         fifoWrData,
  output logic               frameDone,
  output logic               addrHit,
  output logic               errAlign,
  output logic               errCrc,
  output logic               errRunt
);
  localparam int SAT   = (MIN_BYTES > 7) ? MIN_BYTES : 7;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [7:0]         huntSh;
  logic [7:0]         byteSh;
  logic [2:0]         bitCnt;
  logic [CNT_W-1:0]   byteCnt;
  logic [31:0]        crcReg;
  logic [31:0]        crcNext;
  logic [ENTRIES-1:0] matchVec;
  logic [7:0]         assembled;
  logic               byteDone;
  logic               inAddr;
  logic               matchAny;

  assign sfdNow    = ({huntSh[6:0], rxBit} == SFD_PATTERN);
  assign assembled = {rxBit, byteSh[7:1]};
  assign byteDone  = strb.shiftBit && (bitCnt == 3'd7);
  assign inAddr    = (byteCnt < CNT_W'(ADDR_BYTES));
  assign byteSel   = inAddr ? byteCnt[2:0] : 3'd7;
  assign byteVal   = assembled;
  assign matchAny  = |matchVec;
  assign crcNext   = {crcReg[30:0], 1'b0} ^ ((crcReg[31] ^ rxBit) ? CRC_POLY : 32'h0);

  always_ff @(posedge clk) begin
    if (!rstN) huntSh <= '0;
    else if (strb.huntClear) huntSh <= '0;
    else if (strb.huntShift) huntSh <= {huntSh[6:0], rxBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteSh   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      crcReg   <= '1;
      matchVec <= '0;
    end else if (strb.startFrame) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      crcReg   <= '1;
      matchVec <= '1;
    end else if (strb.shiftBit) begin
      byteSh <= assembled;
      bitCnt <= bitCnt + 3'd1;
      crcReg <= crcNext;
      if (byteDone) begin
        if (byteCnt != CNT_W'(SAT)) byteCnt <= byteCnt + CNT_W'(1);
        if (inAddr) matchVec <= matchVec & eqVec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      fifoWrEn <= byteDone && !inAddr && matchAny;
      if (byteDone) fifoWrData <= assembled;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameDone <= 1'b0;
      addrHit   <= 1'b0;
      errAlign  <= 1'b0;
      errCrc    <= 1'b0;
      errRunt   <= 1'b0;
    end else begin
      frameDone <= strb.endFrame;
      addrHit   <= strb.endFrame && !inAddr && matchAny;
      errAlign  <= strb.endFrame && (bitCnt != 3'd0);
      errCrc    <= strb.endFrame && (crcReg != CRC_RESIDUE);
      errRunt   <= strb.endFrame && (byteCnt < CNT_W'(MIN_BYTES));
    end
  end

  // R5: forwarded bytes come only after the six address bytes
  a_r5_fwd_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (byteCnt >= CNT_W'(ADDR_BYTES + 1)));
  // R2: a byte takes eight bit times, so writes never come back to back
  a_r2_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> !fifoWrEn);
  // R6: the done pulse lasts one cycle
  a_r6_single_done: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R11: status flags are qualified by the done pulse
  a_r11_flags_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit || errAlign || errCrc || errRunt) |-> frameDone);
endmodule

// File: rtl/rx_addr_framer.sv
module rx_addr_framer
  import rxf_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int MIN_BYTES = 64,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             carrierSense,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [47:0]      tblWrMac,
  input  logic             tblWrEnable,
  output logic             fifoWrEn,
  output logic [7:0]       fifoWrData,
  output logic             frameDone,
  output logic             addrHit,
  output logic             errAlign,
  output logic             errCrc,
  output logic             errRunt
);
  rxfStrobes_t        strb;
  logic               sfdNow;
  logic [2:0]         byteSel;
  logic [7:0]         byteVal;
  logic [ENTRIES-1:0] eqVec;

  rxf_control u_ctrl (
    .clk(clk), .rstN(rstN), .carrierSense(carrierSense),
    .sfdNow(sfdNow), .strb(strb)
  );

  rxf_addr_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rstN(rstN), .wrEn(tblWrEn), .wrIdx(tblWrIdx),
    .wrMac(tblWrMac), .wrEnable(tblWrEnable),
    .byteSel(byteSel), .byteVal(byteVal), .eqVec(eqVec)
  );

  rxf_datapath #(.ENTRIES(ENTRIES), .MIN_BYTES(MIN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strb(strb), .eqVec(eqVec),
    .sfdNow(sfdNow), .byteSel(byteSel), .byteVal(byteVal),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .frameDone(frameDone), .addrHit(addrHit),
    .errAlign(errAlign), .errCrc(errCrc), .errRunt(errRunt)
  );
endmodule

// File: tb/rx_addr_framer_tb.sv
module rx_addr_framer_tb;
  localparam int ENT = 4;
  localparam int MINB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBit = 1'b0;
  logic carrierSense = 1'b0;
  logic tblWrEn = 1'b0;
  logic [1:0] tblWrIdx = '0;
  logic [47:0] tblWrMac = '0;
  logic tblWrEnable = 1'b0;
  logic fifoWrEn, frameDone, addrHit, errAlign, errCrc, errRunt;
  logic [7:0] fifoWrData;

  rx_addr_framer #(.ENTRIES(ENT), .MIN_BYTES(MINB)) u_dut (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .carrierSense(carrierSense),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrMac(tblWrMac),
    .tblWrEnable(tblWrEnable), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .frameDone(frameDone), .addrHit(addrHit), .errAlign(errAlign),
    .errCrc(errCrc), .errRunt(errRunt)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [47:0] mMac [ENT];
  logic        mEn  [ENT];
  logic        bitsQ [1024];
  int          nBits;
  logic [7:0]  gotBytes [256];
  int          gotN = 0;
  int          doneN = 0;
  logic        gHit, gAlign, gCrc, gRunt;

  always @(negedge clk) begin
    if (fifoWrEn && gotN < 256) begin
      gotBytes[gotN] = fifoWrData;
      gotN++;
    end
    if (frameDone) begin
      doneN++;
      gHit = addrHit; gAlign = errAlign; gCrc = errCrc; gRunt = errRunt;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic b);
    logic [31:0] r;
    r = {c[30:0], 1'b0};
    if (c[31] ^ b) r = r ^ 32'h04C11DB7;
    return r;
  endfunction

  task automatic tblWrite(input int idx, input logic [47:0] mac, input logic en);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = 2'(idx); tblWrMac = mac; tblWrEnable = en;
    @(negedge clk);
    tblWrEn = 1'b0;
    mMac[idx] = mac; mEn[idx] = en;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    carrierSense = 1'b1; rxBit = b;
  endtask

  // Build the frame bits: dest + payload + FCS + trailing bits.
  task automatic buildFrame(input logic [47:0] dst, input int dataLen, input int seed,
                            input int extra, input bit corrupt);
    logic [31:0] c;
    logic [7:0] bv;
    nBits = 0;
    c = '1;
    for (int i = 0; i < dataLen; i++) begin
      bv = (i < 6) ? dst[47-8*i -: 8] : 8'((i * 37 + seed * 11 + 5) & 255);
      for (int k = 0; k < 8; k++) begin
        bitsQ[nBits] = bv[k];
        c = crcStep(c, bv[k]);
        nBits++;
      end
    end
    for (int k = 31; k >= 0; k--) begin
      bitsQ[nBits] = ~c[k];
      nBits++;
    end
    for (int k = 0; k < extra; k++) begin
      bitsQ[nBits] = 1'((k + seed) & 1);
      nBits++;
    end
    if (corrupt) bitsQ[60] = ~bitsQ[60];
  endtask

  task automatic runFrame(input string tag, input logic [47:0] dst, input int dataLen,
                          input int seed, input int extra, input bit corrupt, input int preBits);
    logic [31:0] c;
    logic [7:0] bv;
    logic expHit;
    int nB;
    int mism;
    logic [7:0] sfdBits;
    sfdBits = 8'b10101011;
    buildFrame(dst, dataLen, seed, extra, corrupt);
    gotN = 0; doneN = 0; gHit = 0; gAlign = 0; gCrc = 0; gRunt = 0;
    for (int i = 0; i < preBits; i++) sendBit(1'((i + 1) & 1));
    for (int i = 7; i >= 0; i--) sendBit(sfdBits[i]);
    for (int i = 0; i < nBits; i++) sendBit(bitsQ[i]);
    @(negedge clk);
    carrierSense = 1'b0; rxBit = 1'b0;
    repeat (6) @(negedge clk);
    nB = nBits / 8;
    expHit = 1'b0;
    for (int e = 0; e < ENT; e++) if (mEn[e] && mMac[e] == dst) expHit = 1'b1;
    c = '1;
    for (int i = 0; i < nBits; i++) c = crcStep(c, bitsQ[i]);
    chk({tag, " R6 done count"}, 64'(doneN), 64'd1);
    chk({tag, " R3 R4 addrHit"}, 64'(gHit), 64'(expHit));
    chk({tag, " R7 errAlign"}, 64'(gAlign), 64'((nBits % 8) != 0));
    chk({tag, " R8 errCrc"}, 64'(gCrc), 64'(c != 32'hC704DD7B));
    chk({tag, " R9 errRunt"}, 64'(gRunt), 64'(nB < MINB));
    chk({tag, " R5 fifo count"}, 64'(gotN), expHit ? 64'(nB - 6) : 64'd0);
    mism = 0;
    if (expHit && gotN == nB - 6) begin
      for (int i = 6; i < nB; i++) begin
        for (int k = 0; k < 8; k++) bv[k] = bitsQ[i*8 + k];
        if (gotBytes[i-6] !== bv) mism++;
      end
      chk({tag, " R2 R5 fifo bytes"}, 64'(mism), 64'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
    end
    $finish;
  end

  initial begin
    logic [47:0] m;
    for (int e = 0; e < ENT; e++) begin mMac[e] = '0; mEn[e] = 1'b0; end
    repeat (3) @(negedge clk);
    // R11: reset state of outputs
    chk("R11 reset outputs", {58'd0, fifoWrEn, frameDone, addrHit, errAlign, errCrc, errRunt}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: empty table gives no hit
    runFrame("R11 empty table", 48'h000000000000, 20, 1, 0, 0, 56);

    tblWrite(0, 48'h0A1B2C3D4E5F, 1'b1);
    tblWrite(1, 48'h0102030405F6, 1'b1);
    tblWrite(2, 48'hFFFFFFFFFFFF, 1'b1);
    tblWrite(3, 48'h5A5A5A5A5A5A, 1'b0);

    // R3 R4: each entry, entry 3 disabled
    for (int e = 0; e < ENT; e++) runFrame("R3 R4 entry sweep", mMac[e], 20, e, 0, 0, 56);
    // R3: one wrong byte at each address position
    for (int p = 0; p < 6; p++) begin
      m = mMac[0];
      m[47-8*p -: 8] = m[47-8*p -: 8] ^ 8'h10;
      runFrame("R3 byte mismatch", m, 20, p, 0, 0, 56);
    end
    // R9 R2 R5: lengths across the runt boundary
    for (int L = 6; L <= 16; L++) runFrame("R9 length sweep", mMac[1], L, L, 0, 0, 56);
    // R7 R8: trailing odd bits
    for (int x = 0; x < 8; x++) runFrame("R7 trailing bits", mMac[2], 16, x, x, 0, 56);
    // R8: corrupted payload bit
    runFrame("R8 corrupt", mMac[0], 20, 3, 0, 1, 56);
    // R1: short preamble still locks on the delimiter
    runFrame("R1 short preamble", mMac[1], 14, 9, 0, 0, 4);
    // R6: carrier drop before the delimiter gives no done
    doneN = 0;
    for (int i = 0; i < 20; i++) sendBit(1'((i + 1) & 1));
    @(negedge clk); carrierSense = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 no done before SFD", 64'(doneN), 64'd0);
    // R10 R4: enable entry 3, disable entry 0
    tblWrite(3, mMac[3], 1'b1);
    runFrame("R10 enabled entry", mMac[3], 18, 4, 0, 0, 56);
    tblWrite(0, mMac[0], 1'b0);
    runFrame("R4 disabled entry", mMac[0], 18, 5, 0, 0, 56);
    tblWrite(0, 48'h123456789ABC, 1'b1);
    runFrame("R10 rewritten entry", 48'h123456789ABC, 22, 6, 0, 0, 56);

    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
    end
    $finish;
  end
endmodule